// File: doc/BRIEF.md
# Link integrity and negotiation controller

This block supervises one twisted-pair 10 Mb/s port. It decides whether the link is usable and which duplex mode the port runs in. It sees the line only through a one-cycle strobe for each link pulse that the receive path has already decoded. It produces a one-cycle strobe that asks the transmit path to emit a link pulse. A configuration bit selects one of two algorithms:

- **Plain integrity.** Normal link pulses keep the link alive, and loss of pulses drops it.
- **Negotiation.** The block sends bursts of fast link pulses that carry a 16-bit advertisement word. It decodes the partner's word and settles full or half duplex. It then falls back to plain normal-link-pulse supervision.

A link-disable override pins the link up and takes the duplex mode directly from the advertisement bit.

The state machine has four states:

- **LS_FAIL**: link down, plain algorithm.
- **LS_NEGO**: negotiating.
- **LS_PASS**: link up.
- **LS_FORCED**: link-disable override.

The transitions are:

- FAIL to PASS: after PD_COUNT consecutive normal link pulses.
- FAIL to NEGO: when negotiation is enabled.
- NEGO to PASS: on three identical consecutive bursts (complete) or on PD_COUNT normal link pulses (parallel detect).
- NEGO to FAIL: when negotiation is disabled.
- PASS to NEGO or FAIL: on link loss, depending on the enable bit.
- Any state to NEGO: on a rising negotiation enable, or on a restart pulse while negotiation is enabled.
- Any state to FORCED: while link disable is high.
- FORCED to NEGO or FAIL: when link disable is released.

Reset releases into FAIL. The rising edge of the enable that is seen just after reset starts negotiation, so power-up and reset both lead into a negotiation.

Top module: `lnk_nway_ctrl`

## Requirements
- R1: After reset with `cfg_an_en` high, `an_status` becomes 01 (in progress) and `link_ok` is 0. With `cfg_an_en` low, `an_status` is 00 and `link_ok` is 0.
- R2: While negotiating, the block sends one burst every 33+GAP_SLOTS slots of SLOT_CYC cycles. Even slot 2k always carries a clock pulse, and odd slot 2k+1 carries a pulse when bit k of the local word is 1. The local word is bits[4:0]=00001, bit5=1 (half duplex) and bit6=`cfg_adv_fd` (full duplex), with all other bits 0. A burst therefore holds 19 or 20 pulses.
- R3: Outside negotiation, `tx_pulse` fires once every NLP_CYC cycles. No pulse follows a cycle in which `tx_active` is high.
- R4: The partner word is accepted only after three identical consecutive bursts. A differing burst restarts the count. While negotiating, `an_status` is 01 and the link is down.
- R5: On acceptance, the link passes with `an_status`=10. `duplex_full` is 1 only when `cfg_adv_fd` and partner bit 6 are both 1.
- R6: PD_COUNT consecutive normal link pulses during negotiation give link pass with `an_status`=11 (parallel detect) and half duplex. Fewer pulses leave negotiation running.
- R7: With negotiation disabled, PD_COUNT consecutive normal link pulses in link fail give link pass with `an_status`=00 and half duplex.
- R8: In link pass, each received pulse restarts the loss timer. LOSS_CYC cycles without a pulse drop the link, and negotiation restarts if it is enabled.
- R9: A rising `cfg_an_en`, or a `cfg_an_restart` pulse while `cfg_an_en` is high, restarts negotiation from any state except the override.
- R10: While `cfg_link_dis` is high, `link_ok` is 1 and `an_status` is 00. Received pulses are ignored, normal link pulses are still sent every NLP_CYC cycles, and `duplex_full` follows `cfg_adv_fd`.
- R11: `link_led_n` is the inverse of `link_ok`, so it is low only in link pass or override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rx_pulse | input | 1 | one-cycle strobe per received link pulse |
| tx_active | input | 1 | a frame is being transmitted |
| cfg_an_en | input | 1 | 1 selects negotiation, 0 selects plain integrity |
| cfg_adv_fd | input | 1 | advertise full duplex |
| cfg_link_dis | input | 1 | link-disable override |
| cfg_an_restart | input | 1 | one-cycle negotiation restart request |
| tx_pulse | output | 1 | one-cycle request to emit a link pulse |
| link_ok | output | 1 | link pass status |
| link_led_n | output | 1 | active-low link indicator |
| an_status | output | 2 | 00 idle, 01 in progress, 10 complete, 11 parallel-detected |
| duplex_full | output | 1 | resolved duplex, 1 = full |

## Verification
The bench offers the partner three kinds of bursts and pulse patterns:

- **Identical and mixed bursts.** Runs of identical bursts, and a run broken by a different word, tell an accepted word apart from a count that must restart.
- **Full-duplex and half-duplex partner words.** Bursts with partner bit 6 set and bursts with it clear tell the full-duplex resolution apart from the half-duplex one.
- **Trains of normal link pulses.** Trains of PD_COUNT pulses, and trains one pulse short, tell parallel detect apart from ongoing negotiation. The same trains separate plain-mode pass from a link that stays down.

Pulse silence longer than the loss window is contrasted with pulses spaced inside it. Pulse counts over one transmit period are compared against the expected burst and interval patterns, with and without frame activity and under the override.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic [1:0] {
        LS_FAIL   = 2'd0,
        LS_NEGO   = 2'd1,
        LS_PASS   = 2'd2,
        LS_FORCED = 2'd3
    } lnk_state_e;

    typedef enum logic [1:0] {
        AN_IDLE   = 2'b00,
        AN_BUSY   = 2'b01,
        AN_DONE   = 2'b10,
        AN_PARDET = 2'b11
    } an_stat_e;

    typedef enum logic {
        RX_IDLE    = 1'b0,
        RX_COLLECT = 1'b1
    } rx_phase_e;

    localparam int BURST_SLOTS = 33;
    localparam int WORD_W      = 16;
    localparam int FD_BIT      = 6;

    function automatic logic [WORD_W-1:0] make_adv_word(input logic fd);
        return {9'd0, fd, 1'b1, 5'b00001};
    endfunction

endpackage

// File: rtl/lp_rx_decode.sv
module lp_rx_decode
    import lnk_pkg::*;
#(
    parameter int SLOT_CYC = 15625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pulse_in,
    output logic              nlp_evt,
    output logic              flp_evt,
    output logic [WORD_W-1:0] word_out
);
    localparam int CW = $clog2(SLOT_CYC + 1);

    rx_phase_e         phase;
    logic [5:0]        slot;
    logic [CW-1:0]     cnt;
    logic              seen;
    logic [WORD_W-1:0] shreg;
    logic              seen_n;

    assign seen_n = seen | pulse_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= RX_IDLE;
            slot     <= '0;
            cnt      <= '0;
            seen     <= 1'b0;
            shreg    <= '0;
            word_out <= '0;
            nlp_evt  <= 1'b0;
            flp_evt  <= 1'b0;
        end else begin
            nlp_evt <= 1'b0;
            flp_evt <= 1'b0;
            if (clr) begin
                phase <= RX_IDLE;
            end else begin
                unique case (phase)
                    RX_IDLE: begin
                        if (pulse_in) begin
                            phase <= RX_COLLECT;
                            slot  <= 6'd1;
                            cnt   <= CW'(1);
                            seen  <= 1'b0;
                            shreg <= '0;
                        end
                    end
                    RX_COLLECT: begin
                        if (cnt == CW'(SLOT_CYC)) begin
                            cnt  <= CW'(1);
                            seen <= 1'b0;
                            slot <= slot + 6'd1;
                            if (slot[0]) begin
                                shreg[slot[4:1]] <= seen_n;
                            end else if (!seen_n) begin
                                phase <= RX_IDLE;
                                if (slot == 6'd2) nlp_evt <= 1'b1;
                            end else if (slot == 6'd32) begin
                                phase    <= RX_IDLE;
                                flp_evt  <= 1'b1;
                                word_out <= shreg;
                            end
                        end else begin
                            cnt  <= cnt + CW'(1);
                            seen <= seen_n;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/lp_tx_gen.sv
module lp_tx_gen
    import lnk_pkg::*;
#(
    parameter int SLOT_CYC  = 15625,
    parameter int GAP_SLOTS = 223,
    parameter int NLP_CYC   = 4000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              flp_mode,
    input  logic              hold,
    input  logic [WORD_W-1:0] word,
    output logic              pulse
);
    localparam int PERIOD_SLOTS = BURST_SLOTS + GAP_SLOTS;
    localparam int CW = $clog2(SLOT_CYC);
    localparam int SW = $clog2(PERIOD_SLOTS);
    localparam int NW = $clog2(NLP_CYC);

    logic [CW-1:0] sub;
    logic [SW-1:0] slot_idx;
    logic [NW-1:0] ntmr;
    logic          flp_fire;

    assign flp_fire = (sub == '0) && (slot_idx < SW'(BURST_SLOTS))
                    && (!slot_idx[0] || word[4'(slot_idx >> 1)]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub      <= '0;
            slot_idx <= '0;
            ntmr     <= '0;
            pulse    <= 1'b0;
        end else if (restart) begin
            sub      <= '0;
            slot_idx <= '0;
            ntmr     <= '0;
            pulse    <= 1'b0;
        end else if (flp_mode) begin
            pulse <= flp_fire;
            if (sub == CW'(SLOT_CYC - 1)) begin
                sub      <= '0;
                slot_idx <= (slot_idx == SW'(PERIOD_SLOTS - 1)) ? '0 : slot_idx + SW'(1);
            end else begin
                sub <= sub + CW'(1);
            end
        end else if (hold) begin
            ntmr  <= '0;
            pulse <= 1'b0;
        end else if (ntmr == NW'(NLP_CYC - 1)) begin
            ntmr  <= '0;
            pulse <= 1'b1;
        end else begin
            ntmr  <= ntmr + NW'(1);
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/lnk_nway_ctrl.sv
module lnk_nway_ctrl
    import lnk_pkg::*;
#(
    parameter int SLOT_CYC  = 15625,
    parameter int GAP_SLOTS = 223,
    parameter int NLP_CYC   = 4000000,
    parameter int LOSS_CYC  = 25000000,
    parameter int PD_COUNT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pulse,
    input  logic       tx_active,
    input  logic       cfg_an_en,
    input  logic       cfg_adv_fd,
    input  logic       cfg_link_dis,
    input  logic       cfg_an_restart,
    output logic       tx_pulse,
    output logic       link_ok,
    output logic       link_led_n,
    output logic [1:0] an_status,
    output logic       duplex_full
);
    localparam int PW = $clog2(PD_COUNT + 1);
    localparam int LW = $clog2(LOSS_CYC);

    lnk_state_e        state, nxt;
    an_stat_e          an_q;
    logic              dup_q, an_en_q;
    logic [WORD_W-1:0] last_word, dec_word;
    logic [1:0]        match_cnt;
    logic [PW-1:0]     nlp_cnt;
    logic [LW-1:0]     loss_tmr;
    logic              dec_nlp, dec_flp, rx_gated;
    logic              restart_evt, three_match, pd_hit, loss_hit, st_change;

    assign rx_gated    = rx_pulse & ~cfg_link_dis;
    assign restart_evt = cfg_an_en & (~an_en_q | cfg_an_restart);
    assign three_match = dec_flp && (dec_word == last_word) && (match_cnt == 2'd2);
    assign pd_hit      = dec_nlp && (nlp_cnt == PW'(PD_COUNT - 1));
    assign loss_hit    = (loss_tmr == LW'(LOSS_CYC - 1));
    assign st_change   = (nxt != state) || restart_evt;

    lp_rx_decode #(.SLOT_CYC(SLOT_CYC)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(state == LS_FORCED), .pulse_in(rx_gated),
        .nlp_evt(dec_nlp), .flp_evt(dec_flp), .word_out(dec_word)
    );

    lp_tx_gen #(.SLOT_CYC(SLOT_CYC), .GAP_SLOTS(GAP_SLOTS), .NLP_CYC(NLP_CYC)) u_tx (
        .clk(clk), .rst_n(rst_n), .restart(st_change), .flp_mode(state == LS_NEGO),
        .hold(tx_active), .word(make_adv_word(cfg_adv_fd)), .pulse(tx_pulse)
    );

    always_comb begin
        nxt = state;
        if (cfg_link_dis) begin
            nxt = LS_FORCED;
        end else if (state == LS_FORCED) begin
            nxt = cfg_an_en ? LS_NEGO : LS_FAIL;
        end else if (restart_evt) begin
            nxt = LS_NEGO;
        end else begin
            unique case (state)
                LS_FAIL:   if (cfg_an_en) nxt = LS_NEGO;
                           else if (pd_hit) nxt = LS_PASS;
                LS_NEGO:   if (!cfg_an_en) nxt = LS_FAIL;
                           else if (three_match || pd_hit) nxt = LS_PASS;
                LS_PASS:   if (loss_hit) nxt = cfg_an_en ? LS_NEGO : LS_FAIL;
                LS_FORCED: nxt = LS_FORCED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LS_FAIL;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            an_en_q   <= 1'b0;
            an_q      <= AN_IDLE;
            dup_q     <= 1'b0;
            last_word <= '0;
            match_cnt <= '0;
            nlp_cnt   <= '0;
            loss_tmr  <= '0;
        end else begin
            an_en_q <= cfg_an_en;
            if (st_change) begin
                match_cnt <= '0;
                nlp_cnt   <= '0;
                loss_tmr  <= '0;
                unique case (nxt)
                    LS_NEGO: begin an_q <= AN_BUSY; dup_q <= 1'b0; end
                    LS_PASS: begin
                        if (state == LS_NEGO && three_match) begin
                            an_q  <= AN_DONE;
                            dup_q <= cfg_adv_fd & dec_word[FD_BIT];
                        end else begin
                            an_q  <= (state == LS_NEGO) ? AN_PARDET : AN_IDLE;
                            dup_q <= 1'b0;
                        end
                    end
                    default: begin an_q <= AN_IDLE; dup_q <= 1'b0; end
                endcase
            end else begin
                if (dec_flp) begin
                    last_word <= dec_word;
                    match_cnt <= (match_cnt != 2'd0 && dec_word == last_word)
                               ? match_cnt + 2'd1 : 2'd1;
                    nlp_cnt   <= '0;
                end else if (dec_nlp) begin
                    nlp_cnt <= nlp_cnt + PW'(1);
                end
                if (state == LS_PASS) loss_tmr <= rx_gated ? '0 : loss_tmr + LW'(1);
            end
        end
    end

    assign link_ok     = (state == LS_PASS) || (state == LS_FORCED);
    assign link_led_n  = ~link_ok;
    assign an_status   = an_q;
    assign duplex_full = (state == LS_FORCED) ? cfg_adv_fd : dup_q;

endmodule

// File: rtl/lnk_nway_chk.sv
module lnk_nway_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_pulse,
    input logic       tx_active,
    input logic       cfg_an_en,
    input logic       cfg_adv_fd,
    input logic       cfg_link_dis,
    input logic       cfg_an_restart,
    input logic       tx_pulse,
    input logic       link_ok,
    input logic       link_led_n,
    input logic [1:0] an_status,
    input logic       duplex_full
);
    // R4: negotiation in progress never reports link up
    p_busy_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        an_status == 2'b01 |-> !link_ok);

    // R5: a completed negotiation always has the link up
    p_done_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        an_status == 2'b10 |-> link_ok);

    // R6: parallel detect is link up and half duplex
    p_pardet_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        an_status == 2'b11 |-> (link_ok && !duplex_full));

    // R10: one cycle after link disable is seen, the link is pinned up
    p_forced_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_link_dis)) |-> (link_ok && an_status == 2'b00));

    // R9: a rising enable restarts negotiation
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_an_en && !$past(cfg_an_en) && !cfg_link_dis) |=> an_status == 2'b01);

    // R3: frame activity outside negotiation suppresses the next link pulse
    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && an_status != 2'b01) |=> !tx_pulse);

    // R11: indicator is the inverse of link status
    p_led_r11: assert property (@(posedge clk) disable iff (!rst_n)
        link_led_n != link_ok);
endmodule

bind lnk_nway_ctrl lnk_nway_chk u_chk (.*);

// File: tb/lnk_nway_ctrl_test.sv
`timescale 1ns/1ps
module lnk_nway_ctrl_test;
    localparam int SLOT = 8;
    localparam int GAPS = 8;
    localparam int NLPC = 64;
    localparam int LOSS = 300;
    localparam int PDC  = 3;
    localparam logic [15:0] W_FD = 16'h0061;
    localparam logic [15:0] W_HD = 16'h0021;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_pulse = 0, tx_active = 0, cfg_an_en = 1, cfg_adv_fd = 1;
    logic cfg_link_dis = 0, cfg_an_restart = 0;
    logic tx_pulse, link_ok, link_led_n, duplex_full;
    logic [1:0] an_status;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef struct { string req; logic lok; logic [1:0] st; logic dup; } exp_t;
    exp_t sb_q[$];
    exp_t it;

    always #2 clk = ~clk;

    lnk_nway_ctrl #(.SLOT_CYC(SLOT), .GAP_SLOTS(GAPS), .NLP_CYC(NLPC),
                    .LOSS_CYC(LOSS), .PD_COUNT(PDC)) uut (
        .clk(clk), .rst_n(rst_n), .rx_pulse(rx_pulse), .tx_active(tx_active),
        .cfg_an_en(cfg_an_en), .cfg_adv_fd(cfg_adv_fd), .cfg_link_dis(cfg_link_dis),
        .cfg_an_restart(cfg_an_restart), .tx_pulse(tx_pulse), .link_ok(link_ok),
        .link_led_n(link_led_n), .an_status(an_status), .duplex_full(duplex_full));

    // monitor: pops expected items and compares (R11 checked on every item)
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            n_run++;
            if (link_ok !== it.lok || link_led_n !== !it.lok || an_status !== it.st
                || duplex_full !== it.dup) begin
                n_fail++;
                $display("FAIL %s (R11 led): got lok=%0b led_n=%0b st=%0d dup=%0b expected lok=%0b led_n=%0b st=%0d dup=%0b",
                         it.req, link_ok, link_led_n, an_status, duplex_full,
                         it.lok, !it.lok, it.st, it.dup);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(string req, logic lok, logic [1:0] st, logic dup);
        @(posedge clk); #1;
        sb_q.push_back('{req, lok, st, dup});
        @(negedge clk); #1;
    endtask

    task automatic check_int(string req, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_nlp(int space);
        tick(1); rx_pulse = 1; tick(1); rx_pulse = 0; tick(space - 1);
    endtask

    task automatic send_burst(logic [15:0] w);
        tick(1);
        for (int s = 0; s < 33; s++) begin
            rx_pulse = (s % 2 == 0) || w[s / 2];
            tick(1);
            rx_pulse = 0;
            tick(SLOT - 1);
        end
        tick(40);
    endtask

    task automatic count_tx(int win, output int c);
        c = 0;
        for (int i = 0; i < win; i++) begin
            tick(1);
            if (tx_pulse) c++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int c, g;
        bit found;
        tick(5); rst_n = 1; tick(4);
        expect_state("R1 reset with negotiation", 0, 2'b01, 0);

        count_tx((33 + GAPS) * SLOT, c);
        check_int("R2 burst pulse count fd=1", c, 20);
        cfg_adv_fd = 0; tick(2);
        count_tx((33 + GAPS) * SLOT, c);
        check_int("R2 burst pulse count fd=0", c, 19);
        cfg_adv_fd = 1;

        send_burst(W_FD); send_burst(W_FD); send_burst(W_HD);
        expect_state("R4 differing burst restarts count", 0, 2'b01, 0);
        send_burst(W_HD); send_burst(W_HD);
        expect_state("R5 partner half gives half", 1, 2'b10, 0);

        for (int k = 0; k < 10; k++) send_nlp(50);
        expect_state("R8 pulses keep link", 1, 2'b10, 0);
        tick(LOSS + 50);
        expect_state("R8 loss restarts negotiation", 0, 2'b01, 0);

        send_burst(W_FD); send_burst(W_FD); send_burst(W_FD);
        expect_state("R5 both full gives full", 1, 2'b10, 1);
        tick(LOSS + 50);
        expect_state("R8 loss again", 0, 2'b01, 0);

        for (int k = 0; k < PDC; k++) send_nlp(50);
        expect_state("R6 parallel detect", 1, 2'b11, 0);
        tick(LOSS + 50);
        for (int k = 0; k < PDC - 1; k++) send_nlp(50);
        expect_state("R6 short pulse train keeps negotiating", 0, 2'b01, 0);

        cfg_an_en = 0; tick(2);
        expect_state("R7 plain mode link fail", 0, 2'b00, 0);

        found = 0;
        for (int i = 0; i < 200 && !found; i++) begin tick(1); if (tx_pulse) found = 1; end
        g = 0;
        do begin tick(1); g++; end while (!tx_pulse && g < 200);
        check_int("R3 link pulse interval", g, NLPC);
        tx_active = 1; tick(2);
        count_tx(3 * NLPC, c);
        check_int("R3 no pulse during frame", c, 0);
        tx_active = 0;

        for (int k = 0; k < PDC; k++) send_nlp(50);
        expect_state("R7 plain mode link pass", 1, 2'b00, 0);

        cfg_an_en = 1; tick(2);
        expect_state("R9 enable rise restarts", 0, 2'b01, 0);
        send_burst(W_FD); send_burst(W_FD); send_burst(W_FD);
        expect_state("R9 complete before restart", 1, 2'b10, 1);
        cfg_an_restart = 1; tick(1); cfg_an_restart = 0; tick(1);
        expect_state("R9 restart pulse", 0, 2'b01, 0);

        cfg_link_dis = 1; tick(2);
        expect_state("R10 override up", 1, 2'b00, 1);
        send_burst(W_FD);
        tick(LOSS + 50);
        expect_state("R10 pulses ignored and no loss", 1, 2'b00, 1);
        cfg_adv_fd = 0; tick(1);
        expect_state("R10 duplex follows advertise", 1, 2'b00, 0);
        count_tx(2 * NLPC, c);
        check_int("R10 link pulses still sent", c, 2);

        cfg_link_dis = 0; cfg_an_en = 0; rst_n = 0; tick(3); rst_n = 1; tick(3);
        expect_state("R1 reset without negotiation", 0, 2'b00, 0);

        tick(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule